// File: doc/BRIEF.md
# Low-Frequency Tick Generator with RC Calibration

This block turns a slow reference clock into a periodic tick pulse, one fast-clock cycle wide, that a watchdog or a wakeup timer uses as its time base. The slow reference is chosen by the `xtalOk` input. When the fast crystal clock is running, the slow clock is a square wave that the block makes itself from that clock, with a prescale steered by a configuration register. When the crystal is not available, the slow clock is an external free-running RC oscillator, brought into the fast domain through a two-flop synchronizer. An 8-bit divider sets how many slow-clock periods make up one tick. The current level of the selected slow clock can be read back.

The RC oscillator is not accurate, so the block can also measure it. A half-rate copy of the RC clock is synchronized and its rising edges are detected. While capture is enabled, each such edge latches a 16-bit free-running fast-clock counter into a capture register. The block also computes the modulo-2^16 difference from the previous capture, which is one period of the half-rate signal in fast-clock cycles. Software uses that count to reprogram the divider. A new divider value is applied only at a tick boundary, so no tick ever has an irregular length.

Top module: `lftick_gen`

## Requirements
- R1: With an active divider value N, consecutive tick pulses are exactly (N+1) slow-clock periods apart. Each tick pulse lasts exactly one fast-clock cycle.
- R2: After reset the divider reads 0x03 and the configuration reads 0x27. A write with `wrSel`=0 loads `wrData[7:0]` into the divider. A write with `wrSel`=1 loads `wrData[5:0]` into the configuration. Both values are always visible on `divValue` and `cfgValue`.
- R3: A divider write takes effect at the next tick boundary. The tick period in progress when the write lands keeps the old length, and the period after it uses the new value.
- R4: While `xtalOk`=1 the slow clock is generated from the fast clock. Its half period, in fast-clock cycles, is HALF_UNIT × (cfg[5:3]+1) × (cfg[2] ? 2^cfg[1:0] : 1), where cfg[5:3] is the crystal code, cfg[2] the prescale enable and cfg[1:0] the prescale code.
- R5: While `xtalOk`=0 the slow clock is `rcClk` after a two-flop synchronizer, and `lfPhase` shows that synchronized level. In both modes `lfPhase` is the level of the slow clock currently selected.
- R6: While `capEn`=1, each rising edge of the synchronized `calIn` loads the free-running counter into `capValue`. When a previous capture exists, `capValid` pulses for one cycle.
- R7: When `capValid` is high, `capDiff` equals the number of fast-clock cycles between the last two captures, modulo 2^16. This also holds across counter wraparound.
- R8: While `capEn`=0, no capture occurs: `capValue` holds and `capValid` stays low. After capture is enabled again, the first capture raises no `capValid`, and the second one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xtalOk | input | 1 | 1: use the generated slow clock; 0: use the RC oscillator |
| rcClk | input | 1 | RC oscillator, asynchronous |
| calIn | input | 1 | Half-rate copy of the RC oscillator, asynchronous |
| capEn | input | 1 | Capture enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the divider, 1 selects the configuration |
| wrData | input | 8 | Write data |
| divValue | output | 8 | Divider readback |
| cfgValue | output | 6 | Configuration readback |
| lfPhase | output | 1 | Current slow-clock level |
| tick | output | 1 | Tick pulse, one cycle wide |
| capValue | output | 16 | Last captured counter value |
| capDiff | output | 16 | Difference between the last two captures |
| capValid | output | 1 | One-cycle pulse when a new difference is ready |

## Verification
The assertions check on every cycle that a tick lasts a single cycle, that the tick phase counter never passes the active divider, that the active divider changes only together with a tick, that a capture pulse is never wider than one cycle and only appears while capture is enabled, and that the RC phase readback follows the synchronizer. Exact tick spacing for each divider value, the generated slow-clock period for each configuration code, the moment a divider change lands, and capture differences across counter wraparound can only be shown by the bench. The bench drives clocks of known period and compares the measured intervals with values it computes itself.

// File: rtl/lftick_pkg.sv
package lftick_pkg;

  // register select on the write port
  typedef enum logic {
    SEL_DIV = 1'b0,
    SEL_CFG = 1'b1
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lfRise;     // rising edge of selected slow clock
    logic capTake;    // capture now
    logic capDisarm;  // capture disabled, forget previous sample
  } strobe_t;

  // configuration field positions
  localparam int CFG_W       = 6;
  localparam int CFG_XTAL_LO = 3;
  localparam int CFG_PEN     = 2;
  localparam int CFG_PFQ_LO  = 0;

endpackage

// File: rtl/lftick_ctrl.sv
module lftick_ctrl
  import lftick_pkg::*;
#(
  parameter int          DIV_W     = 8,
  parameter int          HALF_UNIT = 2,
  parameter logic [7:0]  DIV_RST   = 8'h03,
  parameter logic [5:0]  CFG_RST   = 6'h27
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalOk,
  input  logic             rcClk,
  input  logic             calIn,
  input  logic             capEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  output logic [DIV_W-1:0] divReg,
  output logic [CFG_W-1:0] cfgReg,
  output logic             lfPhase,
  output strobe_t          strb
);

  localparam int MAX_HALF = HALF_UNIT * 64;
  localparam int PRES_W   = $clog2(MAX_HALF + 1);

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_W'(DIV_RST);
      cfgReg <= CFG_RST;
    end else if (wrEn) begin
      if (regSel_e'(wrSel) == SEL_DIV) divReg <= DIV_W'(wrData);
      else                             cfgReg <= wrData[CFG_W-1:0];
    end
  end

  // generated slow clock: half period from configuration
  logic [PRES_W-1:0] xtalMul;
  logic [PRES_W-1:0] scaled;
  logic [PRES_W-1:0] halfLen;
  logic [PRES_W-1:0] presCnt;
  logic              xLf;

  always_comb begin
    xtalMul = PRES_W'(cfgReg[CFG_XTAL_LO +: 3]) + PRES_W'(1);
    scaled  = cfgReg[CFG_PEN] ? (xtalMul << cfgReg[CFG_PFQ_LO +: 2]) : xtalMul;
    halfLen = PRES_W'(scaled * PRES_W'(HALF_UNIT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
      xLf     <= 1'b0;
    end else if (presCnt >= halfLen - PRES_W'(1)) begin
      presCnt <= '0;
      xLf     <= ~xLf;
    end else begin
      presCnt <= presCnt + PRES_W'(1);
    end
  end

  // synchronizers
  logic rcMeta, rcSync;
  logic calMeta, calSync, calPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcMeta  <= 1'b0;
      rcSync  <= 1'b0;
      calMeta <= 1'b0;
      calSync <= 1'b0;
      calPrev <= 1'b0;
    end else begin
      rcMeta  <= rcClk;
      rcSync  <= rcMeta;
      calMeta <= calIn;
      calSync <= calMeta;
      calPrev <= calSync;
    end
  end

  // source select and edge detection
  logic lfLevel, lfPrev;
  assign lfLevel = xtalOk ? xLf : rcSync;
  assign lfPhase = lfLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfPrev <= 1'b0;
    else       lfPrev <= lfLevel;
  end

  always_comb begin
    strb.lfRise    = lfLevel & ~lfPrev;
    strb.capTake   = capEn & calSync & ~calPrev;
    strb.capDisarm = ~capEn;
  end

  AST_RC_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (!xtalOk && $past(!xtalOk)) |-> (lfPhase == $past(rcMeta))); // R5

endmodule

// File: rtl/lftick_dpath.sv
module lftick_dpath
  import lftick_pkg::*;
#(
  parameter int         DIV_W   = 8,
  parameter int         CAP_W   = 16,
  parameter logic [7:0] DIV_RST = 8'h03
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [DIV_W-1:0] divReg,
  output logic             tick,
  output logic [CAP_W-1:0] capValue,
  output logic [CAP_W-1:0] capDiff,
  output logic             capValid
);

  // tick divider
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= DIV_W'(DIV_RST);
      tick      <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (strb.lfRise) begin
        if (cnt >= activeDiv) begin
          cnt       <= '0;
          tick      <= 1'b1;
          activeDiv <= divReg;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  // free-running counter and capture
  logic [CAP_W-1:0] freeCnt;
  logic             armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) freeCnt <= '0;
    else       freeCnt <= freeCnt + CAP_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      capValue <= '0;
      capDiff  <= '0;
      capValid <= 1'b0;
    end else begin
      capValid <= 1'b0;
      if (strb.capDisarm) begin
        armed <= 1'b0;
      end else if (strb.capTake) begin
        capValue <= freeCnt;
        armed    <= 1'b1;
        if (armed) begin
          capDiff  <= freeCnt - capValue;
          capValid <= 1'b1;
        end
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= activeDiv); // R1
  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (activeDiv != $past(activeDiv)) |-> tick); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    capValid |=> !capValid); // R6
  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    capValid |-> $past(!strb.capDisarm)); // R8

endmodule

// File: rtl/lftick_gen.sv
module lftick_gen
  import lftick_pkg::*;
#(
  parameter int HALF_UNIT = 2,
  parameter int DIV_W     = 8,
  parameter int CAP_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xtalOk,
  input  logic             rcClk,
  input  logic             calIn,
  input  logic             capEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [7:0]       wrData,
  output logic [DIV_W-1:0] divValue,
  output logic [5:0]       cfgValue,
  output logic             lfPhase,
  output logic             tick,
  output logic [CAP_W-1:0] capValue,
  output logic [CAP_W-1:0] capDiff,
  output logic             capValid
);

  strobe_t strb;

  lftick_ctrl #(
    .DIV_W(DIV_W), .HALF_UNIT(HALF_UNIT), .DIV_RST(8'h03), .CFG_RST(6'h27)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .xtalOk(xtalOk), .rcClk(rcClk), .calIn(calIn),
    .capEn(capEn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .divReg(divValue), .cfgReg(cfgValue), .lfPhase(lfPhase), .strb(strb)
  );

  lftick_dpath #(
    .DIV_W(DIV_W), .CAP_W(CAP_W), .DIV_RST(8'h03)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .divReg(divValue),
    .tick(tick), .capValue(capValue), .capDiff(capDiff), .capValid(capValid)
  );

endmodule

// File: tb/tb_lftick_gen.sv
module tb_lftick_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xtalOk = 1'b0, rcClk = 1'b0, calIn = 1'b0, capEn = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  divValue;
  logic [5:0]  cfgValue;
  logic        lfPhase, tick, capValid;
  logic [15:0] capValue, capDiff;

  int nChk = 0, nFail = 0;
  bit rcRun = 0, calRun = 0, done = 0;
  int rcHalf = 3, calHalf = 1500;

  always #10 clk = ~clk;

  lftick_gen dut (
    .clk(clk), .rstN(rstN), .xtalOk(xtalOk), .rcClk(rcClk), .calIn(calIn),
    .capEn(capEn), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .divValue(divValue), .cfgValue(cfgValue), .lfPhase(lfPhase), .tick(tick),
    .capValue(capValue), .capDiff(capDiff), .capValid(capValid)
  );

  initial forever begin
    if (rcRun) begin repeat (rcHalf) @(negedge clk); rcClk = ~rcClk; end
    else @(negedge clk);
  end

  initial forever begin
    if (calRun) begin repeat (calHalf) @(negedge clk); calIn = ~calIn; end
    else @(negedge clk);
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic gapNext(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!tick);
  endtask

  function automatic int halfOf(input logic [5:0] c);
    int m;
    m = int'(c[5:3]) + 1;
    if (c[2]) m = m << c[1:0];
    return 2 * m;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int g, g2, hi;
    int divList[18] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,100,255};
    logic [5:0] cfgList[4] = '{6'h27, 6'h0D, 6'h00, 6'h38};
    logic [15:0] held;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 div reset", int'(divValue), 3);
    check("R2 cfg reset", int'(cfgValue), 'h27);
    check("R1 tick idle", int'(tick), 0);
    check("R6 valid idle", int'(capValid), 0);

    // R5 phase readback from RC input with static levels
    rcClk = 1'b1; repeat (3) @(negedge clk);
    check("R5 phase high", int'(lfPhase), 1);
    rcClk = 1'b0; repeat (3) @(negedge clk);
    check("R5 phase low", int'(lfPhase), 0);

    // R1 divider sweep on RC source, period 6 cycles
    rcRun = 1;
    foreach (divList[i]) begin
      wr(1'b0, 8'(divList[i]));
      check("R2 div readback", int'(divValue), divList[i]);
      waitTick(); waitTick();
      gapNext(g);
      check("R1 tick gap", g, (divList[i] + 1) * 6);
    end

    // R3 divider change lands at boundary
    wr(1'b0, 8'd3);
    waitTick(); waitTick();
    fork
      begin repeat (2) @(negedge clk); wrEn = 1'b1; wrSel = 1'b0; wrData = 8'd7;
            @(negedge clk); wrEn = 1'b0; end
    join_none
    gapNext(g);
    gapNext(g2);
    check("R3 old period kept", g, 24);
    check("R3 new period used", g2, 48);

    // R4 generated slow clock
    rcRun = 0;
    xtalOk = 1'b1;
    wr(1'b0, 8'd3);
    foreach (cfgList[i]) begin
      wr(1'b1, 8'(cfgList[i]));
      check("R2 cfg readback", int'(cfgValue), int'(cfgList[i]));
      waitTick(); waitTick();
      gapNext(g);
      check("R4 tick gap", g, 4 * 2 * halfOf(cfgList[i]));
      do @(negedge clk); while (lfPhase);
      do @(negedge clk); while (!lfPhase);
      hi = 0;
      while (lfPhase) begin @(negedge clk); hi++; end
      check("R4 half period", hi, halfOf(cfgList[i]));
    end

    // R8 capture disabled
    calRun = 1;
    held = capValue;
    g = 0;
    repeat (8000) begin @(negedge clk); if (capValid) g++; end
    check("R8 no valid while off", g, 0);
    check("R8 capValue held", int'(capValue), int'(held));

    // R8 first capture after enable gives no valid
    capEn = 1'b1;
    held = capValue;
    do @(negedge clk); while (capValue == held);
    check("R8 first capture no valid", int'(capValid), 0);
    held = capValue;
    do @(negedge clk); while (capValue == held);
    check("R6 second capture valid", int'(capValid), 1);
    check("R7 diff", int'(capDiff), 2 * calHalf);

    // R7 long run, crosses counter wraparound
    repeat (25) begin
      do @(negedge clk); while (!capValid);
      check("R7 diff wrap run", int'(capDiff), 2 * calHalf);
      @(negedge clk);
      check("R6 valid one cycle", int'(capValid), 0);
    end

    finishRun();
  end

endmodule